// File: doc/BRIEF.md
# SDRAM Page-Break Energy Monitor

This block is a passive observer placed on the request stream of a four-bank SDRAM. For each accepted access it splits the address into offset, column, bank and row fields and compares the row against an open-row table kept for every bank. A match is a page hit. A mismatch, or an access to a bank with no open row, means the bank must be precharged and the new row activated. The block records which row is now open in that bank.

The monitor counts activations, intra-bank and inter-bank breaks, data words and enabled cycles. It also builds three energy totals in units of 0.1 nJ. Activation energy is charged per activation and transfer energy per word. Static energy is charged per activation and also per enabled cycle. Every count is held in a saturating accumulator.

A small read port returns any counter by index. A synchronous clear input zeroes all counters and closes every bank. The monitor never drives the memory.

Top module: `sdram_pbm_top`

## Requirements
- R1: Address fields from bit 0 upward: a 2-bit byte offset in bits 1:0, an 8-bit column in bits 9:2, the bank in bits 11:10, and the row in bits ROW_W+11:12. Only bank and row decide hit or break.
- R2: After reset or clear every bank is closed. The first accepted access to a closed bank counts one activation and is neither intra nor inter.
- R3: An accepted access whose row equals the row open in its bank is a hit. It adds no activation and no activation or per-activation static energy.
- R4: An accepted access to an open bank with a different row, where the bank equals the bank of the previous accepted access, counts one activation and one intra break.
- R5: An accepted access to an open bank with a different row, where the bank differs from the bank of the previous accepted access, counts one activation and one inter break.
- R6: Each accepted access adds its burst length B to the word counter and B*E_WORD (default 36, i.e. 3.6 nJ) to the data energy.
- R7: Each activation adds E_ACT (default 130) to activation energy and E_STAT_ACT (default 70) to static energy. Each enabled cycle adds E_STAT_CYC (default 1) to static energy.
- R8: The cycle counter increments on every clock with enable high. A request presented while enable is low is ignored.
- R9: Every counter saturates at 2^ACC_W-1 and never wraps or decreases except on clear.
- R10: Clear is synchronous. On the next edge every counter is zero and every bank is closed. A request in the same cycle as clear is dropped.
- R11: rdData is combinational on rdSel: 0 activations, 1 intra, 2 inter, 3 words, 4 cycles, 5 activation energy, 6 data energy, 7 static energy. Indices 8 to 15 read zero.
- R12: After reset all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Monitoring enable; gates cycles and accesses |
| clear | input | 1 | Synchronous clear of counters and open-row table |
| reqValid | input | 1 | Access strobe |
| reqAddr | input | ROW_W+12 | Byte address of the access |
| reqBurst | input | BURST_W | Burst length in words |
| rdSel | input | 4 | Counter index |
| rdData | output | ACC_W | Selected counter value |

## Verification
The bench builds the monitor with ROW_W=3, BURST_W=4 and ACC_W=12. With only eight rows, every combination of previous bank, current bank, old row and new row can be swept, covering hits, intra breaks, inter breaks and cold activations. The 12-bit accumulators saturate after about thirty activations' worth of energy and after 4095 activations. This makes the saturation limit reachable in a few thousand cycles, alongside the enable-low and clear-collision cases.

// File: rtl/sdram_pbm_pkg.sv
package sdram_pbm_pkg;
  localparam int NUM_BANKS   = 4;
  localparam int BANK_W      = 2;
  localparam int COL_W       = 8;
  localparam int OFS_W       = 2;
  localparam int BANK_LSB    = OFS_W + COL_W;
  localparam int FIXED_LOW_W = OFS_W + COL_W + BANK_W;
  localparam int NUM_REGS    = 8;
  localparam int SEL_W       = 4;
  localparam int INC_W       = 32;

  localparam int REG_ACT   = 0;
  localparam int REG_INTRA = 1;
  localparam int REG_INTER = 2;
  localparam int REG_WORDS = 3;
  localparam int REG_CYC   = 4;
  localparam int REG_EACT  = 5;
  localparam int REG_EDATA = 6;
  localparam int REG_ESTAT = 7;

  typedef struct packed {
    logic clr;
    logic tick;
    logic acc;
    logic act;
    logic intra;
    logic inter;
  } pbmStrobe_t;
endpackage

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
  import sdram_pbm_pkg::*;
#(
  parameter int ROW_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic                         clear,
  input  logic                         reqValid,
  input  logic [ROW_W+FIXED_LOW_W-1:0] reqAddr,
  output pbmStrobe_t                   strobe
);
  logic [BANK_W-1:0] reqBank;
  logic [ROW_W-1:0]  reqRow;
  logic              accept;
  logic              bankOpen;
  logic              rowMatch;
  logic [NUM_BANKS-1:0] openValid;
  logic [ROW_W-1:0]  openRow [NUM_BANKS];
  logic [BANK_W-1:0] prevBank;
  logic              unusedLowBits;

  // R1 field extraction
  assign reqBank       = reqAddr[BANK_LSB +: BANK_W];
  assign reqRow        = reqAddr[FIXED_LOW_W +: ROW_W];
  assign unusedLowBits = ^reqAddr[BANK_LSB-1:0];

  assign accept   = enable && reqValid && !clear;
  assign bankOpen = openValid[reqBank];
  assign rowMatch = (openRow[reqBank] == reqRow);

  always_comb begin
    strobe       = '0;
    strobe.clr   = clear;
    strobe.tick  = enable && !clear;
    strobe.acc   = accept;
    strobe.act   = accept && (!bankOpen || !rowMatch);
    strobe.intra = accept && bankOpen && !rowMatch && (reqBank == prevBank);
    strobe.inter = accept && bankOpen && !rowMatch && (reqBank != prevBank);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      openValid <= '0;
      prevBank  <= '0;
    end else if (clear) begin
      openValid <= '0;
      prevBank  <= '0;
    end else if (accept) begin
      openValid[reqBank] <= 1'b1;
      prevBank           <= reqBank;
    end
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          openRow[b] <= '0;
        else if (accept && reqBank == BANK_W'(b))
          openRow[b] <= reqRow;
      end
    end
  endgenerate

  // R2: an accepted access leaves its bank open on the accessed row
  p_open_after_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> openValid[$past(reqBank)] && openRow[$past(reqBank)] == $past(reqRow));

  // R10: clear closes every bank
  p_clear_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> openValid == '0);

  // R3: a repeat of the previous bank and row never activates
  p_repeat_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && $past(accept) && reqBank == $past(reqBank) && reqRow == $past(reqRow))
      |-> !strobe.act);

  // R4/R5: intra and inter never together, and each implies an activation
  p_class_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.intra || strobe.inter) |-> (strobe.act && !(strobe.intra && strobe.inter)));
endmodule

// File: rtl/pbm_dp.sv
module pbm_dp
  import sdram_pbm_pkg::*;
#(
  parameter int BURST_W    = 4,
  parameter int ACC_W      = 48,
  parameter int E_ACT      = 130,
  parameter int E_STAT_ACT = 70,
  parameter int E_WORD     = 36,
  parameter int E_STAT_CYC = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pbmStrobe_t         strb,
  input  logic [BURST_W-1:0] burst,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [ACC_W-1:0]   rdData
);
  localparam int SUM_W = ((ACC_W > INC_W) ? ACC_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'({ACC_W{1'b1}});
  localparam logic [INC_W-1:0] K_ACT   = INC_W'(E_ACT);
  localparam logic [INC_W-1:0] K_SACT  = INC_W'(E_STAT_ACT);
  localparam logic [INC_W-1:0] K_WORD  = INC_W'(E_WORD);
  localparam logic [INC_W-1:0] K_SCYC  = INC_W'(E_STAT_CYC);

  logic [INC_W-1:0] inc  [NUM_REGS];
  logic [ACC_W-1:0] accs [NUM_REGS];
  logic [INC_W-1:0] burstW;

  assign burstW = INC_W'(burst);

  always_comb begin
    inc[REG_ACT]   = INC_W'(strb.act);
    inc[REG_INTRA] = INC_W'(strb.intra);
    inc[REG_INTER] = INC_W'(strb.inter);
    inc[REG_WORDS] = strb.acc ? burstW : '0;
    inc[REG_CYC]   = INC_W'(strb.tick);
    inc[REG_EACT]  = strb.act ? K_ACT : '0;
    inc[REG_EDATA] = strb.acc ? burstW * K_WORD : '0;
    inc[REG_ESTAT] = (strb.act ? K_SACT : '0) + (strb.tick ? K_SCYC : '0);
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_acc
      logic [SUM_W-1:0] sum;
      assign sum = SUM_W'(accs[g]) + SUM_W'(inc[g]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          accs[g] <= '0;
        else if (strb.clr)
          accs[g] <= '0;
        else if (sum > SAT_MAX)
          accs[g] <= SAT_MAX[ACC_W-1:0];
        else
          accs[g] <= sum[ACC_W-1:0];
      end

      // R9: no wrap, no decrease without clear
      p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !strb.clr |=> accs[g] >= $past(accs[g]));

      // R10: clear zeroes every accumulator
      p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        strb.clr |=> accs[g] == '0);
    end
  endgenerate

  // R8: cycle counter steps by one per enabled cycle below the limit
  p_cycle_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.tick && accs[REG_CYC] != SAT_MAX[ACC_W-1:0])
      |=> accs[REG_CYC] == $past(accs[REG_CYC]) + 1'b1);

  // R11 read mux
  always_comb begin
    if (rdSel < SEL_W'(NUM_REGS))
      rdData = accs[rdSel[2:0]];
    else
      rdData = '0;
  end
endmodule

// File: rtl/sdram_pbm_top.sv
module sdram_pbm_top
  import sdram_pbm_pkg::*;
#(
  parameter int ROW_W      = 12,
  parameter int BURST_W    = 4,
  parameter int ACC_W      = 48,
  parameter int E_ACT      = 130,
  parameter int E_STAT_ACT = 70,
  parameter int E_WORD     = 36,
  parameter int E_STAT_CYC = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic                         clear,
  input  logic                         reqValid,
  input  logic [ROW_W+FIXED_LOW_W-1:0] reqAddr,
  input  logic [BURST_W-1:0]           reqBurst,
  input  logic [SEL_W-1:0]             rdSel,
  output logic [ACC_W-1:0]             rdData
);
  pbmStrobe_t strobe;

  pbm_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .clear    (clear),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .strobe   (strobe)
  );

  pbm_dp #(
    .BURST_W    (BURST_W),
    .ACC_W      (ACC_W),
    .E_ACT      (E_ACT),
    .E_STAT_ACT (E_STAT_ACT),
    .E_WORD     (E_WORD),
    .E_STAT_CYC (E_STAT_CYC)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strobe),
    .burst  (reqBurst),
    .rdSel  (rdSel),
    .rdData (rdData)
  );
endmodule

// File: tb/sim_sdram_pbm_top.sv
`timescale 1ns/1ps
module sim_sdram_pbm_top;
  localparam int ROW_W   = 3;
  localparam int BURST_W = 4;
  localparam int ACC_W   = 12;
  localparam int AW      = ROW_W + 12;
  localparam longint MAXV = (64'd1 << ACC_W) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic enable = 0, clear = 0, reqValid = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [BURST_W-1:0] reqBurst = '0;
  logic [3:0] rdSel = '0;
  logic [ACC_W-1:0] rdData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_pbm_top #(.ROW_W(ROW_W), .BURST_W(BURST_W), .ACC_W(ACC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqBurst(reqBurst),
    .rdSel(rdSel), .rdData(rdData)
  );

  // Expected-value model built from the requirements
  longint m [8];
  bit     mOpen [4];
  int     mRow [4];
  int     mPrev;

  function automatic longint sat(longint v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < 8; i++) m[i] = 0;
      for (int i = 0; i < 4; i++) begin mOpen[i] = 0; mRow[i] = 0; end
      mPrev = 0;
    end else if (enable) begin
      m[4] = sat(m[4] + 1);
      m[7] = sat(m[7] + 1);
      if (reqValid) begin
        int bk, rw;
        bk = int'(reqAddr[11:10]);
        rw = int'(reqAddr[AW-1:12]);
        if (!mOpen[bk] || mRow[bk] != rw) begin
          m[0] = sat(m[0] + 1);
          m[5] = sat(m[5] + 130);
          m[7] = sat(m[7] + 70);
          if (mOpen[bk]) begin
            if (bk == mPrev) m[1] = sat(m[1] + 1);
            else             m[2] = sat(m[2] + 1);
          end
        end
        m[3] = sat(m[3] + reqBurst);
        m[6] = sat(m[6] + 36 * reqBurst);
        mOpen[bk] = 1; mRow[bk] = rw; mPrev = bk;
      end
    end
  end

  task automatic chk(longint act, longint exp, string tag, int sel);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s reg%0d actual=%0d expected=%0d", tag, sel, act, exp);
    end
  endtask

  // called at a negedge; reads every register
  task automatic checkAll(string tag);
    for (int s = 0; s < 8; s++) begin
      rdSel = 4'(s);
      #0.1;
      chk(longint'(rdData), m[s], tag, s);
    end
  endtask

  // called at a negedge; presents one access for one cycle
  task automatic access(int bk, int rw, int col, int bl);
    reqValid = 1;
    reqAddr  = {ROW_W'(rw), 2'(bk), 8'(col), 2'(col)};
    reqBurst = BURST_W'(bl);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic doClear();
    clear = 1;
    @(negedge clk);
    clear = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R12 reset");
    rst_n = 1;
    @(negedge clk);
    enable = 1;

    // R2 cold activations, R1 column/offset ignored, R6 bursts
    access(0, 5, 0, 4);
    access(1, 2, 77, 1);
    access(0, 5, 200, 15);
    checkAll("R2 R1 R6 cold and hit");

    // R3/R4/R5 sweep over previous bank, bank, old row, new row
    for (int b1 = 0; b1 < 4; b1++)
      for (int b2 = 0; b2 < 4; b2++)
        for (int ra = 0; ra < 8; ra++)
          for (int rb = 0; rb < 8; rb++) begin
            doClear();
            access(b2, ra, ra * 13, 1 + ra);
            access(b1, 3, rb, rb);
            access(b2, rb, 255 - ra, 15 - rb);
            if (ra == rb && b1 != b2)      checkAll("R3 hit after other bank");
            else if (b1 == b2)             checkAll("R4 intra R7");
            else                           checkAll("R5 inter R7");
          end

    // R8 enable low ignores requests and cycles
    doClear();
    access(2, 1, 0, 3);
    enable = 0;
    access(2, 6, 0, 9);
    access(3, 6, 0, 9);
    checkAll("R8 disabled");
    enable = 1;
    access(2, 1, 0, 2);
    checkAll("R8 re-enabled hit");

    // R10 clear together with a request
    access(1, 4, 0, 5);
    clear = 1;
    access(1, 4, 0, 5);
    clear = 0;
    checkAll("R10 clear collision");
    access(1, 4, 0, 5);
    checkAll("R10 bank closed after clear");

    // R11 unmapped indices
    for (int s = 8; s < 16; s++) begin
      rdSel = 4'(s);
      #0.1;
      chk(longint'(rdData), 0, "R11 unmapped", s);
    end

    // R9 saturation
    doClear();
    for (int i = 0; i < 40; i++) access(0, i % 2, i, 15);
    checkAll("R9 energy saturated");
    for (int i = 0; i < 4200; i++) access(i % 4, (i / 4) % 2, 0, 1);
    checkAll("R9 counters saturated");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule